// File: doc/BRIEF.md
# Burst Serial Control Receiver

This block receives write-only control traffic over a two-wire link: a serial clock that runs only while a frame is in flight, and a serial data line. There is no select line. A frame marks its own start with a leading 1 that the receiver sees on a falling clock edge while it is idle. Two header bits follow. The first asks for a write and the second tells a command from data. After them come eight payload bits, lowest bit first. Both wires are resynchronised into the system clock domain. Bits are taken on falling edges of the serial clock. The frame acts on the first rising edge of the serial clock after its last payload bit.

A command frame selects a device and carries an instruction. The receiver answers only to its own device code, which is a parameter. A matching command unlocks the receiver and restarts the address/data pairing. After that, data frames alternate. The first one names a register and the next one writes that register, for as long as the address falls inside the small register file. The register contents, the last instruction accepted and one-cycle strobes for each command and each write are all on the ports.

Top module: `ctl_burst_rx`

## Requirements
- R1: After reset all register entries and the instruction output are zero, and both strobes are low.
- R2: While idle, a falling serial-clock edge with the data line at 0 is ignored. A frame begins at the first falling edge that sees a 1.
- R3: A frame has 11 bits, in this order: start (1), write flag, command flag, then payload bits 0 to 7. The payload is sent lowest bit first, so payload bit k is frame bit 3+k.
- R4: A frame whose write flag (frame bit 1) is 0 is discarded. It changes no register, no instruction, no lock and no address/data phase.
- R5: A frame takes effect only after the rising serial-clock edge that follows its last bit. While the clock is held low after bit 10, nothing on the outputs changes.
- R6: A command frame (frame bit 2 = 1) with payload[3:0] equal to DEV_CODE (default 4'hA) does four things. It copies payload[7:4] to the instruction output, pulses the command strobe for exactly one system cycle, unlocks the receiver and returns the pairing to the address phase.
- R7: A command frame with any other device code is ignored. The instruction, lock and address/data phase are all left as they were.
- R8: Data frames (frame bit 2 = 0) are ignored until a matching command has been accepted since reset.
- R9: Once unlocked, data frames alternate. The first sets the address and the second writes its payload to register[address], with a one-cycle write strobe, before the pairing returns to the address phase.
- R10: An address of NUM_REGS (5) or more still takes its place in the pairing. The data frame that follows it writes nothing and raises no strobe.
- R11: A matching command received between an address frame and its data frame cancels the pending address. The next data frame is then taken as a new address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Burst serial clock, idles high |
| ser_dat_i | input | 1 | Serial data line |
| regs_o | output | NUM_REGS*DATA_W (40) | Register file, entry i at bits [8i+7:8i] |
| instr_o | output | DATA_W-DEV_W (4) | Last accepted instruction code |
| cmd_stb_o | output | 1 | One-cycle pulse when a command is accepted |
| wr_stb_o | output | 1 | One-cycle pulse when a register is written |

## Verification
A wrong bit counter or framing state shifts every payload bit or eats the next start bit. A walking payload sweep shows this as a wrong register value on the very next write. A lost or inverted lock or address/data phase makes a write land in the wrong register, or not happen at all. This shows within one frame pair, because the bench mirrors every entry and compares them all after each pair. Commit timing errors show directly when the clock is held low after the last bit, since the write strobe count and the register contents must not move until the clock rises.

// File: rtl/ctlrx_pkg.sv
package ctlrx_pkg;

    typedef enum logic [1:0] {
        FR_IDLE  = 2'd0,
        FR_SHIFT = 2'd1,
        FR_HOLD  = 2'd2
    } frame_state_e;

endpackage

// File: rtl/ctlrx_sync_edge.sv
module ctlrx_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic sdat_i,
    output logic fall_o,
    output logic rise_o,
    output logic bit_o
);

    typedef struct packed {
        logic [STAGES-1:0] clk_chain;
        logic [STAGES-1:0] dat_chain;
        logic              prev;
    } sync_t;

    sync_t s_d, s_q;

    logic sclk_s;

    assign sclk_s = s_q.clk_chain[STAGES-1];

    always_comb begin
        s_d           = s_q;
        s_d.clk_chain = {s_q.clk_chain[STAGES-2:0], sclk_i};
        s_d.dat_chain = {s_q.dat_chain[STAGES-2:0], sdat_i};
        s_d.prev      = sclk_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.clk_chain <= '1;
            s_q.dat_chain <= '0;
            s_q.prev      <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign fall_o = s_q.prev & ~sclk_s;
    assign rise_o = ~s_q.prev & sclk_s;
    assign bit_o  = s_q.dat_chain[STAGES-1];

endmodule

// File: rtl/ctlrx_framer.sv
module ctlrx_framer
    import ctlrx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int FRAME_BITS = DATA_W + 3,
    parameter int CNT_W      = $clog2(FRAME_BITS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall_i,
    input  logic              rise_i,
    input  logic              bit_i,
    output logic              done_o,
    output logic              wr_flag_o,
    output logic              cmd_flag_o,
    output logic [DATA_W-1:0] payload_o,
    output logic [CNT_W-1:0]  cnt_o
);

    localparam int BODY_BITS = FRAME_BITS - 1;

    typedef struct packed {
        frame_state_e         state;
        logic [CNT_W-1:0]     cnt;
        logic [BODY_BITS-1:0] body;
        logic                 done;
    } fr_t;

    fr_t f_d, f_q;

    always_comb begin
        f_d      = f_q;
        f_d.done = 1'b0;
        unique case (f_q.state)
            FR_IDLE: begin
                if (fall_i && bit_i) begin
                    f_d.body  = '0;
                    f_d.cnt   = CNT_W'(1);
                    f_d.state = FR_SHIFT;
                end
            end
            FR_SHIFT: begin
                if (fall_i) begin
                    f_d.body[f_q.cnt - CNT_W'(1)] = bit_i;
                    f_d.cnt = f_q.cnt + CNT_W'(1);
                    if (f_q.cnt == CNT_W'(FRAME_BITS - 1)) begin
                        f_d.state = FR_HOLD;
                    end
                end
            end
            FR_HOLD: begin
                if (rise_i) begin
                    f_d.done  = 1'b1;
                    f_d.cnt   = '0;
                    f_d.state = FR_IDLE;
                end
            end
            default: f_d.state = FR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q.state <= FR_IDLE;
            f_q.cnt   <= '0;
            f_q.body  <= '0;
            f_q.done  <= 1'b0;
        end else begin
            f_q <= f_d;
        end
    end

    assign done_o     = f_q.done;
    assign wr_flag_o  = f_q.body[0];
    assign cmd_flag_o = f_q.body[1];
    assign payload_o  = f_q.body[BODY_BITS-1:2];
    assign cnt_o      = f_q.cnt;

endmodule

// File: rtl/ctlrx_decoder.sv
module ctlrx_decoder #(
    parameter int          DATA_W   = 8,
    parameter int          DEV_W    = 4,
    parameter int          NUM_REGS = 5,
    parameter logic [DEV_W-1:0] DEV_CODE = 4'hA,
    parameter int          INSTR_W  = DATA_W - DEV_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         done_i,
    input  logic                         wr_flag_i,
    input  logic                         cmd_flag_i,
    input  logic [DATA_W-1:0]            payload_i,
    output logic [NUM_REGS*DATA_W-1:0]   regs_o,
    output logic [INSTR_W-1:0]           instr_o,
    output logic                         cmd_stb_o,
    output logic                         wr_stb_o
);

    typedef struct packed {
        logic                               unlocked;
        logic                               want_data;
        logic [DATA_W-1:0]                  addr;
        logic [NUM_REGS-1:0][DATA_W-1:0]    regs;
        logic [INSTR_W-1:0]                 instr;
        logic                               cmd_stb;
        logic                               wr_stb;
    } dec_t;

    dec_t d_d, d_q;

    logic dev_match;

    assign dev_match = (payload_i[DEV_W-1:0] == DEV_CODE);

    always_comb begin
        d_d         = d_q;
        d_d.cmd_stb = 1'b0;
        d_d.wr_stb  = 1'b0;
        if (done_i && wr_flag_i) begin
            if (cmd_flag_i) begin
                if (dev_match) begin
                    d_d.unlocked  = 1'b1;
                    d_d.want_data = 1'b0;
                    d_d.instr     = payload_i[DATA_W-1:DEV_W];
                    d_d.cmd_stb   = 1'b1;
                end
            end else if (d_q.unlocked) begin
                if (!d_q.want_data) begin
                    d_d.addr      = payload_i;
                    d_d.want_data = 1'b1;
                end else begin
                    d_d.want_data = 1'b0;
                    for (int i = 0; i < NUM_REGS; i++) begin
                        if (d_q.addr == DATA_W'(i)) begin
                            d_d.regs[i] = payload_i;
                            d_d.wr_stb  = 1'b1;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_q <= '0;
        end else begin
            d_q <= d_d;
        end
    end

    assign regs_o    = d_q.regs;
    assign instr_o   = d_q.instr;
    assign cmd_stb_o = d_q.cmd_stb;
    assign wr_stb_o  = d_q.wr_stb;

endmodule

// File: rtl/ctl_burst_rx.sv
module ctl_burst_rx #(
    parameter int               DATA_W      = 8,
    parameter int               DEV_W       = 4,
    parameter int               NUM_REGS    = 5,
    parameter int               SYNC_STAGES = 2,
    parameter logic [DEV_W-1:0] DEV_CODE    = 4'hA
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ser_clk_i,
    input  logic                       ser_dat_i,
    output logic [NUM_REGS*DATA_W-1:0] regs_o,
    output logic [DATA_W-DEV_W-1:0]    instr_o,
    output logic                       cmd_stb_o,
    output logic                       wr_stb_o
);

    localparam int FRAME_BITS = DATA_W + 3;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam int INSTR_W    = DATA_W - DEV_W;

    logic              ser_fall;
    logic              ser_rise;
    logic              ser_bit;
    logic              frame_done;
    logic              frame_wr;
    logic              frame_cmd;
    logic [DATA_W-1:0] frame_payload;
    logic [CNT_W-1:0]  bit_cnt;

    ctlrx_sync_edge #(
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_i (ser_clk_i),
        .sdat_i (ser_dat_i),
        .fall_o (ser_fall),
        .rise_o (ser_rise),
        .bit_o  (ser_bit)
    );

    ctlrx_framer #(
        .DATA_W     (DATA_W),
        .FRAME_BITS (FRAME_BITS),
        .CNT_W      (CNT_W)
    ) framer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .fall_i     (ser_fall),
        .rise_i     (ser_rise),
        .bit_i      (ser_bit),
        .done_o     (frame_done),
        .wr_flag_o  (frame_wr),
        .cmd_flag_o (frame_cmd),
        .payload_o  (frame_payload),
        .cnt_o      (bit_cnt)
    );

    ctlrx_decoder #(
        .DATA_W   (DATA_W),
        .DEV_W    (DEV_W),
        .NUM_REGS (NUM_REGS),
        .DEV_CODE (DEV_CODE),
        .INSTR_W  (INSTR_W)
    ) decoder_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .done_i     (frame_done),
        .wr_flag_i  (frame_wr),
        .cmd_flag_i (frame_cmd),
        .payload_i  (frame_payload),
        .regs_o     (regs_o),
        .instr_o    (instr_o),
        .cmd_stb_o  (cmd_stb_o),
        .wr_stb_o   (wr_stb_o)
    );

endmodule

// File: rtl/ctlrx_checker.sv
module ctlrx_checker #(
    parameter int REG_BITS   = 40,
    parameter int INSTR_W    = 4,
    parameter int CNT_W      = 4,
    parameter int FRAME_BITS = 11
) (
    input logic                clk,
    input logic                rst_n,
    input logic                rise,
    input logic                done,
    input logic                cmd_stb,
    input logic                wr_stb,
    input logic [REG_BITS-1:0] regs,
    input logic [INSTR_W-1:0]  instr,
    input logic [CNT_W-1:0]    cnt
);

    assert_bit_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(FRAME_BITS));

    assert_commit_after_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(rise));

    assert_cmd_from_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |-> $past(done));

    assert_write_from_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(done));

    assert_one_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_stb, wr_stb}));

    assert_regs_move_on_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (regs != $past(regs)) |-> wr_stb);

    assert_instr_moves_on_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (instr != $past(instr)) |-> cmd_stb);

endmodule

bind ctl_burst_rx ctlrx_checker #(
    .REG_BITS   (NUM_REGS * DATA_W),
    .INSTR_W    (INSTR_W),
    .CNT_W      (CNT_W),
    .FRAME_BITS (FRAME_BITS)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rise    (ser_rise),
    .done    (frame_done),
    .cmd_stb (cmd_stb_o),
    .wr_stb  (wr_stb_o),
    .regs    (regs_o),
    .instr   (instr_o),
    .cnt     (bit_cnt)
);

// File: tb/ctl_burst_rx_tb.sv
`timescale 1ns/1ps
module ctl_burst_rx_tb_top;

    localparam int HB = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b1;
    logic        sdat = 1'b0;
    logic [39:0] regs;
    logic [3:0]  instr;
    logic        cmd_stb;
    logic        wr_stb;

    int checks = 0;
    int fails = 0;
    int cmd_cnt = 0;
    int wr_cnt = 0;
    int exp_wr = 0;
    int exp_cmd = 0;
    logic [7:0] model [5];
    logic [3:0] exp_instr = 4'h0;

    always #4 clk = ~clk;

    ctl_burst_rx dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_clk_i (sclk),
        .ser_dat_i (sdat),
        .regs_o    (regs),
        .instr_o   (instr),
        .cmd_stb_o (cmd_stb),
        .wr_stb_o  (wr_stb)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_stb) cmd_cnt++;
            if (wr_stb)  wr_cnt++;
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_model(input string tag);
        logic [39:0] exp;
        for (int i = 0; i < 5; i++) exp[i*8 +: 8] = model[i];
        check(regs == exp, tag, regs, exp);
        check(wr_cnt == exp_wr, {tag, " strobes"}, wr_cnt, exp_wr);
        check(instr == exp_instr, {tag, " instr"}, instr, exp_instr);
    endtask

    task automatic send_frame(input bit wr, input bit cf, input logic [7:0] pl, input bit hold);
        logic [10:0] b;
        b = {pl, cf, wr, 1'b1};
        for (int k = 0; k < 11; k++) begin
            sdat = b[k];
            wait_cyc(HB);
            sclk = 1'b0;
            wait_cyc(HB);
            if (k == 10 && hold) begin
                wait_cyc(20);
                // R5: nothing moves before the rising edge
                check_model("R5 hold low");
            end
            sclk = 1'b1;
        end
        wait_cyc(HB + 8);
    endtask

    task automatic cmd(input logic [3:0] code, input logic [3:0] ins);
        send_frame(1'b1, 1'b1, {ins, code}, 1'b0);
    endtask

    task automatic dat(input logic [7:0] v);
        send_frame(1'b1, 1'b0, v, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 5; i++) model[i] = 8'h00;
        wait_cyc(5);
        // R1 reset state
        check(regs == 40'h0, "R1 regs", regs, 0);
        check(instr == 4'h0, "R1 instr", instr, 0);
        check(!cmd_stb && !wr_stb, "R1 strobes", {cmd_stb, wr_stb}, 0);
        rst_n = 1'b1;
        wait_cyc(5);

        // R8: locked receiver ignores data
        dat(8'h00);
        dat(8'h55);
        check_model("R8 locked");

        // R7: every wrong device code is ignored and leaves the lock closed
        for (int c = 0; c < 16; c++) begin
            if (c != 10) cmd(4'(c), 4'h5);
        end
        check(cmd_cnt == 0, "R7 no cmd strobe", cmd_cnt, 0);
        dat(8'h01);
        dat(8'h77);
        check_model("R7 still locked");

        // R6: matching command
        cmd(4'hA, 4'h9);
        exp_cmd++;
        exp_instr = 4'h9;
        check(cmd_cnt == exp_cmd, "R6 one-cycle cmd strobe", cmd_cnt, exp_cmd);
        check_model("R6 instr");

        // R9 / R10 / R3: address sweep with asymmetric payloads
        for (int a = 0; a < 8; a++) begin
            logic [7:0] v;
            v = 8'((a * 37 + 11) & 8'hFF);
            dat(8'(a));
            dat(v);
            if (a < 5) begin
                model[a] = v;
                exp_wr++;
            end
            check_model(a < 5 ? "R9 pair write" : "R10 out of range");
        end

        // R3: LSB-first placement
        dat(8'h04);
        dat(8'h01);
        model[4] = 8'h01;
        exp_wr++;
        check_model("R3 lsb first");

        // R2: stray falls with data low while idle
        for (int s = 0; s < 3; s++) begin
            sdat = 1'b0;
            wait_cyc(HB);
            sclk = 1'b0;
            wait_cyc(HB);
            sclk = 1'b1;
            wait_cyc(HB);
        end
        dat(8'h02);
        dat(8'hC3);
        model[2] = 8'hC3;
        exp_wr++;
        check_model("R2 idle noise");

        // R4: read-flag frames are discarded
        dat(8'h03);
        send_frame(1'b0, 1'b0, 8'h11, 1'b0);
        send_frame(1'b0, 1'b1, 8'h6A, 1'b0);
        dat(8'h3C);
        model[3] = 8'h3C;
        exp_wr++;
        check_model("R4 read flag");
        check(cmd_cnt == exp_cmd, "R4 cmd count", cmd_cnt, exp_cmd);

        // R11: matching command cancels pending address
        dat(8'h01);
        cmd(4'hA, 4'h2);
        exp_cmd++;
        exp_instr = 4'h2;
        dat(8'h04);
        dat(8'h99);
        model[4] = 8'h99;
        exp_wr++;
        check_model("R11 phase reset");

        // R7: mismatched command mid-pair keeps the phase
        dat(8'h00);
        cmd(4'h5, 4'hF);
        dat(8'hE7);
        model[0] = 8'hE7;
        exp_wr++;
        check_model("R7 phase kept");

        // R5: commit waits for the rising edge
        dat(8'h02);
        send_frame(1'b1, 1'b0, 8'h5A, 1'b1);
        model[2] = 8'h5A;
        exp_wr++;
        check_model("R5 after rise");

        // R6: instruction sweep
        for (int i = 0; i < 16; i++) begin
            cmd(4'hA, 4'(i));
            exp_cmd++;
            exp_instr = 4'(i);
            check(instr == exp_instr, "R6 instr sweep", instr, exp_instr);
        end
        check(cmd_cnt == exp_cmd, "R6 cmd count", cmd_cnt, exp_cmd);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule